// File: doc/BRIEF.md
# DRAM Rank Boundary Address Decoder

This block turns a physical request address into a memory channel and a rank chip select. Software programs eight one-byte boundary registers, four for each of two channels, through a small register port. Each register holds a cumulative upper limit, in 32 MB units: the memory of its own rank plus the memory of every rank below it. For every valid request the block finds the rank whose window contains the address. It returns the channel, a one-hot chip select and a miss flag one cycle later.

Two channel modes are supported, chosen by a static mode input. In independent mode the two channels form one continuous address space: channel B begins where channel A ends, and a register value is compared directly against the address. In interleaved mode the matching ranks of both channels hold equal values. One address bit picks the channel, and the address is compared against twice the register value, because each rank pair spans both channels.

Top module: `rank_map_decoder`

## Requirements
- R1: Eight 8-bit read/write boundary registers reset to 00h and read back what was written. Channel A ranks 0..3 are at offsets 100h..103h and channel B ranks 0..3 at 180h..183h. Reads return data combinationally on `cfg_rdata`.
- R2: A read from any other offset returns 00h. A write to any other offset changes no register.
- R3: Slot index s runs 0..7 in the order A0..A3, B0..B3. In independent mode, with u = address bits [35:25], slot s is selected when limit(s-1) <= u < limit(s), where limit(-1) = 0.
- R4: In independent mode channel B continues after channel A, so B rank 0's lower bound is A rank 3's limit. `dec_chan` is 0 for channel A and 1 for channel B.
- R5: A rank whose limit equals the previous limit is empty and is never selected. A channel B programmed entirely with A rank 3's value matches no address.
- R6: In interleaved mode the channel is address bit 6. Rank r of that channel is selected when 2*limit(r-1) <= u < 2*limit(r), with rank 0's lower bound at 0.
- R7: When no window contains the address, `dec_miss` is 1, `dec_cs` is 0 and `dec_chan` is 0. With every register at its reset value, every address misses.
- R8: `dec_valid` is 1 exactly one cycle after a cycle with `req_valid` = 1. When `dec_valid` is 0, `dec_cs`, `dec_chan` and `dec_miss` are all 0.
- R9: A request in the same cycle as a register write is decoded with the old value. The next request sees the new value.
- R10: `dec_cs` is one-hot on a hit, with bit index channel*4 + rank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_ilv | input | 1 | 1 = interleaved channels, 0 = independent |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 12 | Register offset |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data for `cfg_addr` |
| req_valid | input | 1 | Request address is valid |
| req_addr | input | 36 | Physical request address |
| dec_valid | output | 1 | Decode result valid |
| dec_chan | output | 1 | Selected channel |
| dec_cs | output | 8 | One-hot rank chip select |
| dec_miss | output | 1 | Address above all populated memory |

## Verification
On every cycle the assertions check these cycle-level properties:
- the one-cycle valid latency and the all-zero idle outputs;
- the one-hot shape of the chip select and the absence of selects on a miss;
- the agreement between the channel output and the chip-select half that is set;
- the channel taken from address bit 6 in interleaved mode;
- the zero read data for undefined offsets.

Only the bench's scenarios can show that the right rank is chosen. They cover cumulative independent windows, empty ranks skipped, the doubled interleaved spans, the empty-channel-B programming and the ordering of a write against a request in the same cycle.

// File: rtl/rank_map_pkg.sv
package rank_map_pkg;

  // Width used for all boundary arithmetic; wide enough for any unit index.
  localparam int CMP_W = 32;

  // Limit in address units; doubled when the channels interleave.
  function automatic logic [CMP_W-1:0] scaled_limit(input logic [CMP_W-1:0] lim,
                                                     input logic ilv);
    return ilv ? (lim << 1) : lim;
  endfunction

  // Half-open window test: lo <= unit < hi.
  function automatic logic span_hit(input logic [CMP_W-1:0] unit,
                                    input logic [CMP_W-1:0] lo,
                                    input logic [CMP_W-1:0] hi);
    return (unit >= lo) && (unit < hi);
  endfunction

endpackage

// File: rtl/rank_regfile.sv
module rank_regfile #(
  parameter int RANK_N = 4,
  parameter int LIM_W  = 8,
  parameter int CFG_AW = 12,
  parameter logic [CFG_AW-1:0] BASE_A = 12'h100,
  parameter logic [CFG_AW-1:0] BASE_B = 12'h180
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_wr,
  input  logic [CFG_AW-1:0]          cfg_addr,
  input  logic [LIM_W-1:0]           cfg_wdata,
  output logic [LIM_W-1:0]           rd_data,
  output logic                       addr_hit,
  output logic [2*RANK_N*LIM_W-1:0]  lim_flat
);
  localparam int SLOT_N = 2 * RANK_N;

  logic [SLOT_N-1:0] slot_sel;
  logic [LIM_W-1:0]  slot_q [SLOT_N];

  for (genvar s = 0; s < SLOT_N; s++) begin : g_slot
    localparam logic [CFG_AW-1:0] OFF = (s < RANK_N) ?
      CFG_AW'(BASE_A + CFG_AW'(s)) : CFG_AW'(BASE_B + CFG_AW'(s - RANK_N));

    assign slot_sel[s] = (cfg_addr == OFF);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     slot_q[s] <= '0;
      else if (cfg_wr && slot_sel[s]) slot_q[s] <= cfg_wdata;
    end

    assign lim_flat[s*LIM_W +: LIM_W] = slot_q[s];
  end

  assign addr_hit = |slot_sel;

  always_comb begin
    rd_data = '0;
    for (int s = 0; s < SLOT_N; s++) begin
      if (slot_sel[s]) rd_data = rd_data | slot_q[s];
    end
  end
endmodule

// File: rtl/rank_window.sv
module rank_window
  import rank_map_pkg::*;
#(
  parameter int UNIT_W = 11,
  parameter int LIM_W  = 8,
  parameter int RANK_N = 4,
  parameter int SLOT   = 0
) (
  input  logic              ilv,
  input  logic              chan_bit,
  input  logic [UNIT_W-1:0] unit,
  input  logic [LIM_W-1:0]  lim_prev,
  input  logic [LIM_W-1:0]  lim_self,
  output logic              hit
);
  localparam int  RANK_IDX  = SLOT % RANK_N;
  localparam logic CHAN_IDX = (SLOT >= RANK_N);

  logic [CMP_W-1:0] lo_bound;
  logic [CMP_W-1:0] hi_bound;
  logic             lo_is_zero;
  logic             chan_ok;

  // Slot 0 always starts at 0; in interleaved mode every rank 0 does.
  assign lo_is_zero = (SLOT == 0) || (ilv && (RANK_IDX == 0));
  assign lo_bound   = lo_is_zero ? '0 : scaled_limit(CMP_W'(lim_prev), ilv);
  assign hi_bound   = scaled_limit(CMP_W'(lim_self), ilv);
  assign chan_ok    = !ilv || (chan_bit == CHAN_IDX);
  assign hit        = chan_ok && span_hit(CMP_W'(unit), lo_bound, hi_bound);
endmodule

// File: rtl/rank_pick.sv
module rank_pick #(
  parameter int N = 8
) (
  input  logic [N-1:0] hits,
  output logic [N-1:0] first,
  output logic         any
);
  // Isolate the lowest set bit: lowest slot index wins.
  assign first = hits & (~hits + N'(1));
  assign any   = |hits;
endmodule

// File: rtl/rank_map_decoder.sv
module rank_map_decoder #(
  parameter int ADDR_W     = 36,
  parameter int UNIT_SHIFT = 25,
  parameter int ILV_BIT    = 6,
  parameter int RANK_N     = 4,
  parameter int LIM_W      = 8,
  parameter int CFG_AW     = 12,
  parameter logic [CFG_AW-1:0] BASE_A = 12'h100,
  parameter logic [CFG_AW-1:0] BASE_B = 12'h180
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mode_ilv,
  input  logic                cfg_wr,
  input  logic [CFG_AW-1:0]   cfg_addr,
  input  logic [LIM_W-1:0]    cfg_wdata,
  output logic [LIM_W-1:0]    cfg_rdata,
  input  logic                req_valid,
  input  logic [ADDR_W-1:0]   req_addr,
  output logic                dec_valid,
  output logic                dec_chan,
  output logic [2*RANK_N-1:0] dec_cs,
  output logic                dec_miss
);
  localparam int SLOT_N = 2 * RANK_N;
  localparam int UNIT_W = ADDR_W - UNIT_SHIFT;

  logic [SLOT_N*LIM_W-1:0] lim_flat;
  logic [LIM_W-1:0]        rf_rdata;
  logic                    cfg_hit;
  logic [UNIT_W-1:0]       req_unit;
  logic                    chan_bit;
  logic [SLOT_N-1:0]       win_hit;
  logic [SLOT_N-1:0]       pick_cs;
  logic                    pick_any;
  logic                    pick_chan;
  logic                    addr_low_unused;

  rank_regfile #(
    .RANK_N(RANK_N), .LIM_W(LIM_W), .CFG_AW(CFG_AW),
    .BASE_A(BASE_A), .BASE_B(BASE_B)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .rd_data(rf_rdata), .addr_hit(cfg_hit),
    .lim_flat(lim_flat)
  );

  assign cfg_rdata = cfg_hit ? rf_rdata : '0;

  assign req_unit = req_addr[ADDR_W-1:UNIT_SHIFT];
  assign chan_bit = req_addr[ILV_BIT];
  assign addr_low_unused = ^{req_addr[UNIT_SHIFT-1:ILV_BIT+1], req_addr[ILV_BIT-1:0]};

  for (genvar s = 0; s < SLOT_N; s++) begin : g_win
    logic [LIM_W-1:0] prev_lim;
    if (s == 0) begin : g_first
      assign prev_lim = '0;
    end else begin : g_rest
      assign prev_lim = lim_flat[(s-1)*LIM_W +: LIM_W];
    end

    rank_window #(
      .UNIT_W(UNIT_W), .LIM_W(LIM_W), .RANK_N(RANK_N), .SLOT(s)
    ) u_win (
      .ilv(mode_ilv), .chan_bit(chan_bit), .unit(req_unit),
      .lim_prev(prev_lim), .lim_self(lim_flat[s*LIM_W +: LIM_W]),
      .hit(win_hit[s])
    );
  end

  rank_pick #(.N(SLOT_N)) u_pick (
    .hits(win_hit), .first(pick_cs), .any(pick_any)
  );

  assign pick_chan = |pick_cs[SLOT_N-1:RANK_N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid <= 1'b0;
      dec_chan  <= 1'b0;
      dec_cs    <= '0;
      dec_miss  <= 1'b0;
    end else begin
      dec_valid <= req_valid;
      dec_chan  <= req_valid && pick_chan;
      dec_cs    <= req_valid ? pick_cs : '0;
      dec_miss  <= req_valid && !pick_any;
    end
  end
endmodule

// File: rtl/rank_map_checks.sv
module rank_map_checks #(
  parameter int RANK_N  = 4,
  parameter int ADDR_W  = 36,
  parameter int ILV_BIT = 6,
  parameter int LIM_W   = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                mode_ilv,
  input logic                req_valid,
  input logic [ADDR_W-1:0]   req_addr,
  input logic                dec_valid,
  input logic                dec_chan,
  input logic [2*RANK_N-1:0] dec_cs,
  input logic                dec_miss,
  input logic                cfg_hit,
  input logic [LIM_W-1:0]    cfg_rdata
);
  p_cs_onehot0_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dec_cs));

  p_hit_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_miss) |-> ($countones(dec_cs) == 1));

  p_miss_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dec_miss |-> (dec_valid && dec_cs == '0 && !dec_chan));

  p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> dec_valid);

  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!dec_valid && dec_cs == '0 && !dec_miss && !dec_chan));

  p_chan_half_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !dec_miss) |-> (dec_chan == (|dec_cs[2*RANK_N-1:RANK_N])));

  p_ilv_chan_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode_ilv) |=> (dec_miss || dec_chan == $past(req_addr[ILV_BIT])));

  p_undef_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_hit |-> (cfg_rdata == '0));
endmodule

bind rank_map_decoder rank_map_checks #(
  .RANK_N(RANK_N), .ADDR_W(ADDR_W), .ILV_BIT(ILV_BIT), .LIM_W(LIM_W)
) u_checks (
  .clk(clk), .rst_n(rst_n), .mode_ilv(mode_ilv), .req_valid(req_valid),
  .req_addr(req_addr), .dec_valid(dec_valid), .dec_chan(dec_chan),
  .dec_cs(dec_cs), .dec_miss(dec_miss), .cfg_hit(cfg_hit), .cfg_rdata(cfg_rdata)
);

// File: tb/tb_rank_map_decoder.sv
`timescale 1ns/1ps
module tb_rank_map_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_ilv = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [11:0] cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic        req_valid = 1'b0;
  logic [35:0] req_addr = '0;
  logic        dec_valid, dec_chan, dec_miss;
  logic [7:0]  dec_cs;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string cur_tag = "R8";

  always #2 clk = ~clk;

  rank_map_decoder dut (
    .clk(clk), .rst_n(rst_n), .mode_ilv(mode_ilv), .cfg_wr(cfg_wr),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .req_valid(req_valid), .req_addr(req_addr), .dec_valid(dec_valid),
    .dec_chan(dec_chan), .dec_cs(dec_cs), .dec_miss(dec_miss)
  );

  // ---------------- reference model ----------------
  int regs_m [8];
  logic       exp_v = 0, exp_ch = 0, exp_miss = 0;
  logic [7:0] exp_cs = '0;

  function automatic int slot_of(input logic [11:0] a);
    if (a >= 12'h100 && a <= 12'h103) return int'(a - 12'h100);
    if (a >= 12'h180 && a <= 12'h183) return int'(a - 12'h180) + 4;
    return -1;
  endfunction

  function automatic void ref_decode(input logic [35:0] a, input bit ilv,
      output logic [7:0] cs, output logic ch, output logic miss);
    int u;
    u = int'(a >> 25);
    cs = '0; ch = 0; miss = 1;
    for (int s = 0; s < 8; s++) begin
      int lo, hi, rk, c;
      rk = s % 4; c = s / 4;
      if (ilv) begin
        if (c != int'(a[6])) continue;
        lo = (rk == 0) ? 0 : 2 * regs_m[s-1];
        hi = 2 * regs_m[s];
      end else begin
        lo = (s == 0) ? 0 : regs_m[s-1];
        hi = regs_m[s];
      end
      if (u >= lo && u < hi) begin
        cs[s] = 1'b1; ch = c[0]; miss = 0;
        break;
      end
    end
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) regs_m[i] = 0;
      exp_v = 0; exp_cs = '0; exp_ch = 0; exp_miss = 0;
    end else begin
      exp_v = req_valid;
      if (req_valid) ref_decode(req_addr, mode_ilv, exp_cs, exp_ch, exp_miss);
      else begin exp_cs = '0; exp_ch = 0; exp_miss = 0; end
      if (cfg_wr && slot_of(cfg_addr) >= 0) regs_m[slot_of(cfg_addr)] = int'(cfg_wdata);
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, expv, $time);
    end
  endtask

  // Per-clock comparison against the model, half a cycle after the edge.
  always @(negedge clk) begin
    #1;
    if (!done) begin
      int sl, er;
      sl = slot_of(cfg_addr);
      er = (sl >= 0) ? regs_m[sl] : 0;
      check(dec_valid === exp_v, cur_tag, "model dec_valid", int'(dec_valid), int'(exp_v));
      check(dec_cs === exp_cs, cur_tag, "model dec_cs", int'(dec_cs), int'(exp_cs));
      check(dec_chan === exp_ch, cur_tag, "model dec_chan", int'(dec_chan), int'(exp_ch));
      check(dec_miss === exp_miss, cur_tag, "model dec_miss", int'(dec_miss), int'(exp_miss));
      check(cfg_rdata === er[7:0], (sl >= 0) ? "R1" : "R2", "model cfg_rdata",
            int'(cfg_rdata), er);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk); cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_wr = 0;
  endtask

  task automatic rd_expect(input logic [11:0] a, input logic [7:0] e, input string tag);
    @(negedge clk); cfg_addr = a; #1;
    check(cfg_rdata === e, tag, $sformatf("read %0h", a), int'(cfg_rdata), int'(e));
  endtask

  function automatic logic [35:0] ua(input int u, input bit b6);
    logic [35:0] a;
    a = 36'(u) << 25;
    a[6] = b6;
    return a;
  endfunction

  task automatic probe(input logic [35:0] a, input logic [7:0] ecs, input bit ech,
                       input bit emiss, input string tag);
    cur_tag = tag;
    @(negedge clk); req_valid = 1; req_addr = a;
    @(negedge clk); req_valid = 0; #1;
    check(dec_valid === 1'b1, tag, "dec_valid", int'(dec_valid), 1);
    check(dec_cs === ecs, tag, $sformatf("cs for %0h", a), int'(dec_cs), int'(ecs));
    check(dec_chan === ech, tag, "dec_chan", int'(dec_chan), int'(ech));
    check(dec_miss === emiss, tag, "dec_miss", int'(dec_miss), int'(emiss));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  // ---------------- scenarios ----------------
  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(dec_valid === 0 && dec_cs === 0 && dec_miss === 0, "R8", "reset outputs",
          int'(dec_cs), 0);
    rst_n = 1;

    // R1: reset values
    rd_expect(12'h100, 8'h00, "R1");
    rd_expect(12'h183, 8'h00, "R1");
    // R7: empty map misses everything
    probe(ua(0, 0), 8'h00, 0, 1, "R7");

    // R3/R4/R5: independent map A=2,2,4,6 B=7,9,9,12
    wr(12'h100, 2); wr(12'h101, 2); wr(12'h102, 4); wr(12'h103, 6);
    wr(12'h180, 7); wr(12'h181, 9); wr(12'h182, 9); wr(12'h183, 12);
    rd_expect(12'h102, 8'h04, "R1");
    rd_expect(12'h183, 8'h0c, "R1");

    // R2: undefined offsets
    wr(12'h104, 8'h55); wr(12'h17f, 8'h66); wr(12'h184, 8'h77);
    rd_expect(12'h104, 8'h00, "R2");
    rd_expect(12'h184, 8'h00, "R2");
    rd_expect(12'h103, 8'h06, "R2");
    rd_expect(12'h180, 8'h07, "R2");

    probe(ua(0, 0),  8'h01, 0, 0, "R3");
    probe(ua(1, 1),  8'h01, 0, 0, "R3");
    probe(ua(2, 0),  8'h04, 0, 0, "R5");
    probe(ua(3, 0),  8'h04, 0, 0, "R3");
    probe(ua(5, 0),  8'h08, 0, 0, "R3");
    probe(ua(6, 0),  8'h10, 1, 0, "R4");
    probe(ua(7, 1),  8'h20, 1, 0, "R4");
    probe(ua(9, 0),  8'h80, 1, 0, "R5");
    probe(ua(11, 0), 8'h80, 1, 0, "R10");
    probe(ua(12, 0), 8'h00, 0, 1, "R7");
    probe(36'hf_ffff_ffff, 8'h00, 0, 1, "R7");

    // R9: write in the same cycle as a request sees the old map
    cur_tag = "R9";
    @(negedge clk); req_valid = 1; req_addr = ua(2, 0);
    cfg_wr = 1; cfg_addr = 12'h101; cfg_wdata = 3;
    @(negedge clk); req_valid = 0; cfg_wr = 0; #1;
    check(dec_cs === 8'h04, "R9", "same-cycle write", int'(dec_cs), 4);
    probe(ua(2, 0), 8'h02, 0, 0, "R9");

    // R5: empty channel B equals A rank 3
    wr(12'h180, 6); wr(12'h181, 6); wr(12'h182, 6); wr(12'h183, 6);
    probe(ua(6, 0), 8'h00, 0, 1, "R5");
    probe(ua(5, 1), 8'h08, 0, 0, "R5");

    // R6: interleaved map, both channels 1,2,2,3
    wr(12'h100, 1); wr(12'h101, 2); wr(12'h102, 2); wr(12'h103, 3);
    wr(12'h180, 1); wr(12'h181, 2); wr(12'h182, 2); wr(12'h183, 3);
    probe(ua(1, 0), 8'h02, 0, 0, "R3");
    @(negedge clk); mode_ilv = 1;
    probe(ua(0, 0), 8'h01, 0, 0, "R6");
    probe(ua(1, 1), 8'h10, 1, 0, "R6");
    probe(ua(1, 0), 8'h01, 0, 0, "R6");
    probe(ua(2, 0), 8'h02, 0, 0, "R6");
    probe(ua(3, 1), 8'h20, 1, 0, "R6");
    probe(ua(4, 0), 8'h08, 0, 0, "R5");
    probe(ua(5, 1), 8'h80, 1, 0, "R10");
    probe(ua(6, 1), 8'h00, 0, 1, "R7");

    // R8: back-to-back requests, then idle
    cur_tag = "R8";
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); req_valid = 1; req_addr = ua(i, i[0]);
    end
    @(negedge clk); req_valid = 0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule